// File: doc/BRIEF.md
# Ethernet Transmit Frame Encapsulator

This block turns a byte stream of payload into a complete Ethernet frame on an 8-bit transmit data path, one byte per clock. When a payload byte is offered while the block is idle, it sends a run of 0x55 synchronisation bytes followed by the 0xD5 start-of-frame delimiter. It then passes the payload through, fills short payloads with zero bytes up to the minimum length, and closes the frame with a 32-bit frame check sequence. An idle gap follows, and only then does the block accept the next frame.

The upstream source offers bytes with a valid flag and marks the final byte with a last flag. The block pulls bytes with its ready output, and ready is only raised when the next transmit byte slot belongs to the payload. The source must keep payload bytes coming without a break. If valid drops while ready is high, the frame is closed at that point and treated as if the byte before were the last.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is high, and after it is released with no input, tx_en is 0, tx_data is 0x00 and s_ready is 0.
- R2: Seeing s_valid high while idle starts a frame: the first PRE_LEN (default 6) bytes with tx_en high are 0x55, and no input byte is consumed for them.
- R3: The byte after the 0x55 run is 0xD5. The accepted payload bytes then follow in order, one per clock, each appearing in the cycle after its handshake.
- R4: s_ready is high only while a frame is in progress and the next byte slot is a payload slot. It is low when idle, during the 0x55 run, during padding, during the check sequence and during the gap.
- R5: A payload shorter than MIN_LEN (default 60) bytes is followed by 0x00 bytes until payload plus fill equals MIN_LEN. Longer payloads get no fill.
- R6: After payload and fill come four check bytes: the CRC-32 (reflected polynomial 0xEDB88320, start value 0xFFFFFFFF, result inverted) computed over payload and fill, sent least significant byte first.
- R7: tx_en stays high for every byte from the first 0x55 to the last check byte, with no hole, and the frame length matches R2 to R6. Whenever tx_en is low, tx_data is 0x00.
- R8: Between the end of one frame and the start of the next, tx_en is low for at least IFG_LEN (default 12) cycles. If the next frame is already waiting, the gap is exactly IFG_LEN cycles.
- R9: If s_valid is low in a cycle where s_ready is high, the payload ends with the bytes accepted so far, and padding and check bytes follow as in R5 and R6. A frame whose s_valid falls before the delimiter goes out with an all-zero payload of MIN_LEN bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one byte time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 8 | Payload byte offered by the source |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | Offered byte is the final payload byte |
| s_ready | output | 1 | Block takes the offered byte at this edge |
| tx_data | output | 8 | Transmit byte, registered |
| tx_en | output | 1 | Transmit byte is part of a frame, registered |

## Verification
The bench builds the block with its default values: 6 synchronisation bytes, a 60-byte minimum payload and a 12-cycle gap. With these values the padding edge can be hit directly with payloads of 1, 59, 60, 61 and 64 bytes. Both early-close cases are covered: the empty frame and a close after ten bytes. Two frames sent back to back pin the gap to exactly twelve idle cycles.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SFD,
    PH_PAY,
    PH_PAD,
    PH_FCS,
    PH_GAP
  } phase_t;

  localparam logic [7:0]  SYNC_BYTE  = 8'h55;
  localparam logic [7:0]  DELIM_BYTE = 8'hD5;
  localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
  localparam int          FCS_BYTES  = 4;

  // one byte of the reflected CRC-32 shift, LSB first
  function automatic logic [31:0] crc_step(input logic [31:0] cur, input logic [7:0] din);
    logic [31:0] c;
    c = cur ^ {24'h0, din};
    for (int b = 0; b < 8; b++) begin
      if (c[0]) c = (c >> 1) ^ CRC_POLY_R;
      else      c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      crc_q <= CRC_SEED;
    end else if (en) begin
      crc_q <= crc_step(crc_q, din);
    end
  end

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int PRE_LEN = 6,
  parameter int MIN_LEN = 60,
  parameter int IFG_LEN = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  s_data,
  input  logic        s_valid,
  input  logic        s_last,
  output logic        s_ready,
  input  logic [31:0] crc_q,
  output logic        crc_clear,
  output logic        crc_en,
  output logic [7:0]  crc_byte,
  output logic [7:0]  tx_data,
  output logic        tx_en
);

  localparam int CNT_MAX0 = (PRE_LEN > IFG_LEN) ? PRE_LEN : IFG_LEN;
  localparam int CNT_MAX  = (CNT_MAX0 > FCS_BYTES) ? CNT_MAX0 : FCS_BYTES;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int LEN_W    = $clog2(MIN_LEN + 1);

  localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] FCS_END = CNT_W'(FCS_BYTES);
  localparam logic [CNT_W-1:0] GAP_END = CNT_W'((IFG_LEN > 0) ? IFG_LEN - 1 : 0);
  localparam logic [LEN_W-1:0] LEN_END = LEN_W'(MIN_LEN);

  phase_t           ph, ph_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [LEN_W-1:0] len, len_n;
  logic             last_q, last_n;
  logic [7:0]       byte_n;
  logic             en_n;
  logic [31:0]      fcs_shift;

  assign s_ready   = (ph == PH_SFD) || ((ph == PH_PAY) && !last_q);
  assign crc_clear = (ph == PH_PRE);
  assign fcs_shift = (~crc_q) >> {cnt, 3'b000};

  always_comb begin
    ph_n     = ph;
    cnt_n    = cnt;
    len_n    = len;
    last_n   = last_q;
    byte_n   = 8'h00;
    en_n     = 1'b1;
    crc_en   = 1'b0;
    crc_byte = 8'h00;
    case (ph)
      PH_IDLE: begin
        en_n = 1'b0;
        if (s_valid) begin
          ph_n   = PH_PRE;
          cnt_n  = CNT_W'(1);
          len_n  = '0;
          last_n = 1'b0;
          byte_n = SYNC_BYTE;
          en_n   = 1'b1;
        end
      end
      PH_PRE: begin
        if (cnt >= PRE_END) begin
          ph_n   = PH_SFD;
          byte_n = DELIM_BYTE;
        end else begin
          cnt_n  = cnt + CNT_W'(1);
          byte_n = SYNC_BYTE;
        end
      end
      PH_SFD, PH_PAY, PH_PAD: begin
        if (s_ready && s_valid) begin
          ph_n     = PH_PAY;
          byte_n   = s_data;
          crc_en   = 1'b1;
          crc_byte = s_data;
          last_n   = s_last;
          if (len != LEN_END) len_n = len + LEN_W'(1);
        end else if (len != LEN_END) begin
          ph_n     = PH_PAD;
          byte_n   = 8'h00;
          crc_en   = 1'b1;
          crc_byte = 8'h00;
          len_n    = len + LEN_W'(1);
        end else begin
          ph_n   = PH_FCS;
          cnt_n  = CNT_W'(1);
          byte_n = ~crc_q[7:0];
        end
      end
      PH_FCS: begin
        if (cnt >= FCS_END) begin
          ph_n  = PH_GAP;
          cnt_n = CNT_W'(1);
          en_n  = 1'b0;
        end else begin
          byte_n = fcs_shift[7:0];
          cnt_n  = cnt + CNT_W'(1);
        end
      end
      PH_GAP: begin
        en_n = 1'b0;
        if (cnt >= GAP_END) ph_n = PH_IDLE;
        else                cnt_n = cnt + CNT_W'(1);
      end
      default: begin
        ph_n = PH_IDLE;
        en_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      len     <= '0;
      last_q  <= 1'b0;
      tx_data <= 8'h00;
      tx_en   <= 1'b0;
    end else begin
      ph      <= ph_n;
      cnt     <= cnt_n;
      len     <= len_n;
      last_q  <= last_n;
      tx_data <= byte_n;
      tx_en   <= en_n;
    end
  end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int PRE_LEN = 6,
  parameter int MIN_LEN = 60,
  parameter int IFG_LEN = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic [7:0] tx_data,
  output logic       tx_en
);

  logic [31:0] crc_q;
  logic        crc_clear;
  logic        crc_en;
  logic [7:0]  crc_byte;

  eth_tx_seq #(
    .PRE_LEN(PRE_LEN),
    .MIN_LEN(MIN_LEN),
    .IFG_LEN(IFG_LEN)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .s_data   (s_data),
    .s_valid  (s_valid),
    .s_last   (s_last),
    .s_ready  (s_ready),
    .crc_q    (crc_q),
    .crc_clear(crc_clear),
    .crc_en   (crc_en),
    .crc_byte (crc_byte),
    .tx_data  (tx_data),
    .tx_en    (tx_en)
  );

  eth_tx_crc u_crc (
    .clk  (clk),
    .rst  (rst),
    .clear(crc_clear),
    .en   (crc_en),
    .din  (crc_byte),
    .crc_q(crc_q)
  );

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
  parameter int PRE_LEN = 6,
  parameter int MIN_LEN = 60,
  parameter int IFG_LEN = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       s_ready,
  input logic [7:0] tx_data,
  input logic       tx_en
);

  localparam logic [15:0] MIN_FRAME = 16'(PRE_LEN + 1 + MIN_LEN + 4);
  localparam logic [15:0] PRE_N     = 16'(PRE_LEN);
  localparam logic [15:0] GAP_N     = 16'(IFG_LEN);

  logic [15:0] idle_cnt;
  logic [15:0] fidx;
  logic        prev_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= GAP_N;
      fidx     <= '0;
      prev_en  <= 1'b0;
    end else begin
      prev_en <= tx_en;
      if (tx_en) begin
        idle_cnt <= '0;
        if (fidx != 16'hFFFF) fidx <= fidx + 16'd1;
      end else begin
        fidx <= '0;
        if (idle_cnt != 16'hFFFF) idle_cnt <= idle_cnt + 16'd1;
      end
    end
  end

  // R2
  sync_run_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && (fidx < PRE_N)) |-> (tx_data == 8'h55));

  // R3
  delim_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && (fidx == PRE_N)) |-> (tx_data == 8'hD5));

  // R4
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (tx_en && (fidx >= PRE_N)));

  // R5
  min_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && prev_en) |-> (fidx >= MIN_FRAME));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> (tx_data == 8'h00));

  // R8
  gap_len_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !prev_en) |-> (idle_cnt >= GAP_N));

endmodule

bind eth_tx_framer eth_tx_framer_chk #(
  .PRE_LEN(PRE_LEN),
  .MIN_LEN(MIN_LEN),
  .IFG_LEN(IFG_LEN)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .s_ready(s_ready),
  .tx_data(tx_data),
  .tx_en  (tx_en)
);

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_LEN    = 6;
  localparam int MIN_LEN    = 60;
  localparam int IFG_LEN    = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic [7:0] tx_data;
  logic       tx_en;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         flen_q[$];

  int  idle_run = 0;
  int  last_gap = -1;
  int  idx = 0;
  int  cur_len = 0;
  bit  seen = 1'b0;
  bit  prev_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_framer #(
    .PRE_LEN(PRE_LEN),
    .MIN_LEN(MIN_LEN),
    .IFG_LEN(IFG_LEN)
  ) u_dut (
    .clk    (clk),
    .rst    (rst),
    .s_data (s_data),
    .s_valid(s_valid),
    .s_last (s_last),
    .s_ready(s_ready),
    .tx_data(tx_data),
    .tx_en  (tx_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input logic [7:0] d[$]);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    foreach (d[i]) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ d[i][b]) c = (c >> 1) ^ 32'hEDB8_8320;
        else                c = c >> 1;
      end
    end
    return ~c;
  endfunction

  // scoreboard driver side: expected frame bytes with requirement tags
  task automatic push_frame(input logic [7:0] pl[$]);
    logic [7:0] body[$];
    logic [31:0] f;
    body = pl;
    for (int i = 0; i < PRE_LEN; i++) begin exp_q.push_back(8'h55); tag_q.push_back("R2"); end
    exp_q.push_back(8'hD5); tag_q.push_back("R3");
    foreach (pl[i]) begin exp_q.push_back(pl[i]); tag_q.push_back("R3"); end
    while (body.size() < MIN_LEN) begin
      body.push_back(8'h00); exp_q.push_back(8'h00); tag_q.push_back("R5");
    end
    f = ref_fcs(body);
    for (int k = 0; k < 4; k++) begin exp_q.push_back(f[8*k +: 8]); tag_q.push_back("R6"); end
    flen_q.push_back(PRE_LEN + 1 + body.size() + 4);
  endtask

  task automatic send(input int n, input logic [7:0] seed, input bit close);
    logic [7:0] pl[$];
    for (int i = 0; i < n; i++) pl.push_back(8'(seed + 8'(i * 7)));
    push_frame(pl);
    for (int i = 0; i < n; i++) begin
      bit r;
      s_data  = pl[i];
      s_valid = 1'b1;
      s_last  = close && (i == n - 1);
      do begin
        r = s_ready;
        @(posedge clk);
        if (!r) @(negedge clk);
      end while (!r);
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  // R9: valid falls before the delimiter
  task automatic send_empty();
    logic [7:0] pl[$];
    push_frame(pl);
    s_data  = 8'hAA;
    s_valid = 1'b1;
    s_last  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (IFG_LEN + 4) @(negedge clk);
  endtask

  // scoreboard monitor side
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_en) begin
        if (!prev_en) begin
          if (seen) chk(idle_run >= IFG_LEN, "R8", "idle gap", idle_run, IFG_LEN);
          last_gap = idle_run;
          seen     = 1'b1;
          idx      = 0;
          cur_len  = (flen_q.size() != 0) ? flen_q.pop_front() : 0;
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected frame byte", tx_data, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(tx_data == e, t, $sformatf("byte %0d", idx), tx_data, e);
        end
        if (idx < PRE_LEN || idx >= cur_len - 4)
          chk(!s_ready, "R4", "ready outside payload", s_ready, 0);
        idx++;
        idle_run = 0;
      end else begin
        if (prev_en) chk(idx == cur_len, "R7", "frame length", idx, cur_len);
        idle_run++;
        chk(tx_data == 8'h00, "R7", "idle data", tx_data, 0);
        chk(!s_ready, "R4", "ready while idle", s_ready, 0);
      end
      prev_en = tx_en;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, %0d bytes still expected", exp_q.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_en == 1'b0,     "R1", "tx_en in reset",   tx_en, 0);
    chk(tx_data == 8'h00,  "R1", "tx_data in reset", tx_data, 0);
    chk(s_ready == 1'b0,   "R1", "s_ready in reset", s_ready, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(tx_en == 1'b0,     "R1", "tx_en idle",   tx_en, 0);
    chk(s_ready == 1'b0,   "R1", "s_ready idle", s_ready, 0);

    send(64, 8'h10, 1'b1); wait_done();   // R3 R6 no fill
    send(60, 8'h3C, 1'b1); wait_done();   // R5 boundary, no fill
    send(59, 8'hC1, 1'b1); wait_done();   // R5 one fill byte
    send(1,  8'hFF, 1'b1); wait_done();   // R5 long fill
    send_empty();          wait_done();   // R9 empty frame
    send(10, 8'h5A, 1'b0); wait_done();   // R9 early close

    send(61, 8'h01, 1'b1);                // R8 back to back
    send(20, 8'h80, 1'b1);
    wait_done();
    chk(last_gap == IFG_LEN, "R8", "back-to-back gap", last_gap, IFG_LEN);
    chk(flen_q.size() == 0, "R7", "frames left over", flen_q.size(), 0);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule